// File: doc/BRIEF.md
# Probe Super-Frame Stream Checker

This block sits behind the receive side of a neural recording probe link. Its input is a stream of words, grouped into blocks of 34 words. A block starts with a word flagged as the start of the block. The first word carries a sync type code, the second carries a 24-bit frame counter, and the last 32 words carry ADC samples. The block checks that the sync types arrive in the order a super frame requires. It checks that the frame counter advances by one on each block. It tags every accepted sample with its channel number and its kind, AP or LFP. It also marks the first sample of each super frame and the first sample of each ultra frame.

A super frame is one LFP block (code 816) followed by twelve AP blocks (code 207). Twelve super frames form an ultra frame. Across an ultra frame the LFP block moves through channel groups 0 to 11. Sync errors, counter discontinuities and a bad first counter value are each reported as one-cycle pulses. A saturating counter totals the drops. A level enable gates the whole stream. While the enable is low, input is ignored and the parser returns to searching for a super-frame start.

Top module: `probe_frame_checker`

## Requirements
- R1: A word with `in_valid_i` and `in_sob_i` high opens a block of 34 words. Word 0 is the header, with the sync code in bits 15:0. Word 1 is the counter, with the count in bits 23:0. Words 2 to 33 are samples 0 to 31. A valid word outside a block that lacks `in_sob_i` is ignored. A new start word before the current block is complete abandons that block and pulses `sync_err_o`.
- R2: Each sample word of an accepted block gives `out_valid_o` high one cycle later. `out_sample_o` equals bits 9:0 of the word, and all higher bits are discarded. Dropped blocks give no output.
- R3: After reset, blocks are dropped until a block with code 816 arrives. Once locked, the expected order is one 816 block followed by exactly twelve 207 blocks, repeating. A header that breaks this order pulses `sync_err_o` one cycle after the header. If the out-of-place header is 816, lock is regained at once as super frame 0. Any other code drops blocks until the next 816 arrives.
- R4: Sample s of the j-th AP block (j = 0..11) in a super frame has `out_chan_o` = 32j+s and `out_is_lfp_o` = 0.
- R5: Sample s of the LFP block in super frame k of an ultra frame has `out_chan_o` = 32k+s and `out_is_lfp_o` = 1. k counts 0..11 and wraps.
- R6: `out_sosf_o` is high on sample 0 of every LFP block. `out_souf_o` is high only when, in addition, k = 0.
- R7: Each counter word must equal the previous one plus 1, modulo 2^24. If it does not, `drop_o` pulses one cycle after the counter word. `drop_count_o` then rises by one and holds at its maximum. The next expected value follows from the received count.
- R8: The first counter word after reset, or after the enable returns high, is checked against zero rather than against continuity. A nonzero value pulses `seq_err_o` and does not count as a drop.
- R9: While `enable_i` is low, no output is produced and input words are ignored. The sync search restarts. `drop_count_o` keeps its value.
- R10: During reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Stream enable |
| in_valid_i | input | 1 | Input word valid |
| in_sob_i | input | 1 | Word opens a new block |
| in_data_i | input | 24 | Input word |
| out_valid_o | output | 1 | Output sample valid |
| out_sample_o | output | 10 | Sample value |
| out_chan_o | output | 9 | AP or LFP channel index |
| out_is_lfp_o | output | 1 | Sample is from an LFP block |
| out_sosf_o | output | 1 | First sample of a super frame |
| out_souf_o | output | 1 | First sample of an ultra frame |
| sync_err_o | output | 1 | Block order or framing violation pulse |
| drop_o | output | 1 | Counter discontinuity pulse |
| seq_err_o | output | 1 | Nonzero first count pulse |
| drop_count_o | output | 16 | Saturating drop total |

## Verification
Two full ultra frames, with idle gaps inside blocks and stray words between them, test channel numbering and the wrap of the LFP group. A counter that jumps near 2^24 and then wraps through zero tells a real drop from a legitimate wrap. Several kinds of order faults are injected: a thirteenth AP block, an early 816, an unknown code, and a block cut short. Together they tell immediate resync apart from a full drop until the next 816. Enable toggling with zero and nonzero restart counts, followed by a burst of truncated blocks whose counters jump, tests the start-of-count check and the saturation of the drop total.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_AP   = 2'd1,
    KIND_LFP  = 2'd2
  } blk_kind_e;
endpackage

// File: rtl/pfc_word_seq.sv
module pfc_word_seq #(
  parameter int BLK_WORDS = 34,
  parameter int SIDX_W    = 5,
  localparam int IDX_W    = $clog2(BLK_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              valid_i,
  input  logic              sob_i,
  output logic              hdr_stb_o,
  output logic              abort_o,
  output logic              cnt_stb_o,
  output logic              smp_stb_o,
  output logic              smp_first_o,
  output logic [SIDX_W-1:0] smp_idx_o
);
  logic             in_blk_q;
  logic [IDX_W-1:0] wpos_q;
  logic             take, body;

  always_comb begin
    take        = enable_i & valid_i;
    body        = take & ~sob_i & in_blk_q;
    hdr_stb_o   = take & sob_i;
    abort_o     = hdr_stb_o & in_blk_q;
    cnt_stb_o   = body & (wpos_q == IDX_W'(1));
    smp_stb_o   = body & (wpos_q >= IDX_W'(2));
    smp_first_o = body & (wpos_q == IDX_W'(2));
    smp_idx_o   = SIDX_W'(wpos_q - IDX_W'(2));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_blk_q <= 1'b0;
      wpos_q   <= '0;
    end else if (!enable_i) begin
      in_blk_q <= 1'b0;
      wpos_q   <= '0;
    end else if (hdr_stb_o) begin
      in_blk_q <= 1'b1;
      wpos_q   <= IDX_W'(1);
    end else if (body) begin
      if (wpos_q == IDX_W'(BLK_WORDS - 1)) begin
        in_blk_q <= 1'b0;
        wpos_q   <= '0;
      end else begin
        wpos_q <= wpos_q + IDX_W'(1);
      end
    end
  end

  a_r1_pos_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wpos_q < IDX_W'(BLK_WORDS));
  a_r1_idle_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_blk_q |-> wpos_q == '0);
endmodule

// File: rtl/pfc_order_fsm.sv
module pfc_order_fsm
  import pfc_pkg::*;
#(
  parameter int CODE_W    = 16,
  parameter int CODE_LFP  = 816,
  parameter int CODE_AP   = 207,
  parameter int AP_BLKS   = 12,
  parameter int SF_PER_UF = 12,
  parameter int POS_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              hdr_stb_i,
  input  logic              abort_i,
  input  logic [CODE_W-1:0] code_i,
  output blk_kind_e         kind_o,
  output logic [POS_W-1:0]  pos_o,
  output logic              sync_err_o
);
  logic             locked_q, locked_n;
  logic [POS_W-1:0] ap_q, ap_n, sf_q, sf_n, pos_n;
  blk_kind_e        kind_n;
  logic             err_n, live, is_lfp, is_ap, want_lfp;

  always_comb begin
    is_lfp   = code_i == CODE_W'(CODE_LFP);
    is_ap    = code_i == CODE_W'(CODE_AP);
    live     = locked_q & ~abort_i;
    want_lfp = ap_q == POS_W'(AP_BLKS);
    locked_n = locked_q;
    ap_n     = ap_q;
    sf_n     = sf_q;
    kind_n   = kind_o;
    pos_n    = pos_o;
    err_n    = 1'b0;
    if (hdr_stb_i) begin
      err_n = abort_i;
      if (!live || (is_lfp && !want_lfp)) begin
        // hunting, or an early 816: restart as super frame 0
        err_n    = abort_i | (live & is_lfp);
        locked_n = is_lfp;
        ap_n     = '0;
        sf_n     = '0;
        kind_n   = is_lfp ? KIND_LFP : KIND_NONE;
        pos_n    = '0;
      end else if (want_lfp && is_lfp) begin
        sf_n   = (sf_q == POS_W'(SF_PER_UF - 1)) ? '0 : sf_q + POS_W'(1);
        ap_n   = '0;
        kind_n = KIND_LFP;
        pos_n  = sf_n;
      end else if (!want_lfp && is_ap) begin
        kind_n = KIND_AP;
        pos_n  = ap_q;
        ap_n   = ap_q + POS_W'(1);
      end else begin
        err_n    = 1'b1;
        locked_n = 1'b0;
        kind_n   = KIND_NONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q   <= 1'b0;
      ap_q       <= '0;
      sf_q       <= '0;
      kind_o     <= KIND_NONE;
      pos_o      <= '0;
      sync_err_o <= 1'b0;
    end else if (!enable_i) begin
      locked_q   <= 1'b0;
      ap_q       <= '0;
      sf_q       <= '0;
      kind_o     <= KIND_NONE;
      pos_o      <= '0;
      sync_err_o <= 1'b0;
    end else begin
      locked_q   <= locked_n;
      ap_q       <= ap_n;
      sf_q       <= sf_n;
      kind_o     <= kind_n;
      pos_o      <= pos_n;
      sync_err_o <= err_n;
    end
  end

  a_r3_ap_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_q <= POS_W'(AP_BLKS));
  a_r5_sf_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sf_q < POS_W'(SF_PER_UF));
  a_r3_err_after_hdr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_err_o |-> $past(hdr_stb_i));
  a_r1_abort_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> sync_err_o);
endmodule

// File: rtl/pfc_cnt_check.sv
module pfc_cnt_check #(
  parameter int CNT_W  = 24,
  parameter int DROP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              cnt_stb_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              drop_o,
  output logic              seq_err_o,
  output logic [DROP_W-1:0] drop_count_o
);
  logic             first_q;
  logic [CNT_W-1:0] exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q      <= 1'b1;
      exp_q        <= '0;
      drop_o       <= 1'b0;
      seq_err_o    <= 1'b0;
      drop_count_o <= '0;
    end else if (!enable_i) begin
      first_q   <= 1'b1;
      drop_o    <= 1'b0;
      seq_err_o <= 1'b0;
    end else begin
      drop_o    <= 1'b0;
      seq_err_o <= 1'b0;
      if (cnt_stb_i) begin
        exp_q <= cnt_i + CNT_W'(1);
        if (first_q) begin
          first_q   <= 1'b0;
          seq_err_o <= cnt_i != '0;
        end else if (cnt_i != exp_q) begin
          drop_o <= 1'b1;
          if (drop_count_o != '1) drop_count_o <= drop_count_o + DROP_W'(1);
        end
      end
    end
  end

  a_r7_count_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> (drop_count_o == $past(drop_count_o) + DROP_W'(1)) || ($past(drop_count_o) == '1));
  a_r7_count_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drop_o |-> $stable(drop_count_o));
  a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drop_o && seq_err_o));
endmodule

// File: rtl/probe_frame_checker.sv
module probe_frame_checker
  import pfc_pkg::*;
#(
  parameter int CNT_W        = 24,
  parameter int CODE_W       = 16,
  parameter int SAMPLE_W     = 10,
  parameter int SAMP_PER_BLK = 32,
  parameter int AP_BLKS      = 12,
  parameter int SF_PER_UF    = 12,
  parameter int CODE_LFP     = 816,
  parameter int CODE_AP      = 207,
  parameter int DROP_W       = 16,
  localparam int BLK_WORDS   = SAMP_PER_BLK + 2,
  localparam int SIDX_W      = $clog2(SAMP_PER_BLK),
  localparam int MAX_BLKS    = (AP_BLKS > SF_PER_UF) ? AP_BLKS : SF_PER_UF,
  localparam int POS_W       = $clog2(MAX_BLKS + 1),
  localparam int CH_W        = $clog2(MAX_BLKS * SAMP_PER_BLK)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enable_i,
  input  logic                in_valid_i,
  input  logic                in_sob_i,
  input  logic [CNT_W-1:0]    in_data_i,
  output logic                out_valid_o,
  output logic [SAMPLE_W-1:0] out_sample_o,
  output logic [CH_W-1:0]     out_chan_o,
  output logic                out_is_lfp_o,
  output logic                out_sosf_o,
  output logic                out_souf_o,
  output logic                sync_err_o,
  output logic                drop_o,
  output logic                seq_err_o,
  output logic [DROP_W-1:0]   drop_count_o
);
  logic              hdr_stb, abort, cnt_stb, smp_stb, smp_first;
  logic [SIDX_W-1:0] smp_idx;
  blk_kind_e         kind;
  logic [POS_W-1:0]  pos;
  logic [CH_W-1:0]   chan_n;
  logic              emit, lfp_blk;

  pfc_word_seq #(.BLK_WORDS(BLK_WORDS), .SIDX_W(SIDX_W)) u_seq (
    .clk_i, .rst_ni, .enable_i,
    .valid_i    (in_valid_i),
    .sob_i      (in_sob_i),
    .hdr_stb_o  (hdr_stb),
    .abort_o    (abort),
    .cnt_stb_o  (cnt_stb),
    .smp_stb_o  (smp_stb),
    .smp_first_o(smp_first),
    .smp_idx_o  (smp_idx)
  );

  pfc_order_fsm #(
    .CODE_W(CODE_W), .CODE_LFP(CODE_LFP), .CODE_AP(CODE_AP),
    .AP_BLKS(AP_BLKS), .SF_PER_UF(SF_PER_UF), .POS_W(POS_W)
  ) u_order (
    .clk_i, .rst_ni, .enable_i,
    .hdr_stb_i (hdr_stb),
    .abort_i   (abort),
    .code_i    (in_data_i[CODE_W-1:0]),
    .kind_o    (kind),
    .pos_o     (pos),
    .sync_err_o(sync_err_o)
  );

  pfc_cnt_check #(.CNT_W(CNT_W), .DROP_W(DROP_W)) u_cnt (
    .clk_i, .rst_ni, .enable_i,
    .cnt_stb_i   (cnt_stb),
    .cnt_i       (in_data_i),
    .drop_o      (drop_o),
    .seq_err_o   (seq_err_o),
    .drop_count_o(drop_count_o)
  );

  always_comb begin
    emit    = smp_stb & (kind != KIND_NONE);
    lfp_blk = kind == KIND_LFP;
    chan_n  = CH_W'(pos) * CH_W'(SAMP_PER_BLK) + CH_W'(smp_idx);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      out_sample_o <= '0;
      out_chan_o   <= '0;
      out_is_lfp_o <= 1'b0;
      out_sosf_o   <= 1'b0;
      out_souf_o   <= 1'b0;
    end else begin
      out_valid_o <= emit;
      out_sosf_o  <= emit & smp_first & lfp_blk;
      out_souf_o  <= emit & smp_first & lfp_blk & (pos == '0);
      if (emit) begin
        out_sample_o <= in_data_i[SAMPLE_W-1:0];
        out_chan_o   <= chan_n;
        out_is_lfp_o <= lfp_blk;
      end
    end
  end

  a_r4_chan_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_chan_o < CH_W'(MAX_BLKS * SAMP_PER_BLK));
  a_r6_souf_in_sosf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_souf_o |-> out_sosf_o && out_is_lfp_o && out_valid_o);
  a_r9_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !out_valid_o);
  a_r2_valid_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i && !in_sob_i));
endmodule

// File: tb/probe_frame_checker_bench.sv
`timescale 1ns/1ps
module probe_frame_checker_bench;
  localparam int DW = 6;
  localparam int DMAX = (1 << DW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, in_valid = 1'b0, in_sob = 1'b0;
  logic [23:0] in_data = '0;
  logic out_valid, out_is_lfp, out_sosf, out_souf, sync_err, drop, seq_err;
  logic [9:0] out_sample;
  logic [8:0] out_chan;
  logic [DW-1:0] drop_count;

  always #4 clk = ~clk;

  probe_frame_checker #(.DROP_W(DW)) u_probe_frame_checker (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .in_valid_i(in_valid),
    .in_sob_i(in_sob), .in_data_i(in_data), .out_valid_o(out_valid),
    .out_sample_o(out_sample), .out_chan_o(out_chan), .out_is_lfp_o(out_is_lfp),
    .out_sosf_o(out_sosf), .out_souf_o(out_souf), .sync_err_o(sync_err),
    .drop_o(drop), .seq_err_o(seq_err), .drop_count_o(drop_count)
  );

  int checks = 0, errors = 0;
  string vtag = "R10", etag = "R10";

  // reference model state
  int m_inblk = 0, m_w = 0, m_lock = 0, m_ap = 0, m_sf = 0, m_kind = 0, m_pos = 0;
  int m_first = 1, m_drops = 0;
  int unsigned m_exp = 0;
  bit e_valid = 0, e_lfp = 0, e_sosf = 0, e_souf = 0, e_serr = 0, e_drop = 0, e_seq = 0;
  int e_sample = 0, e_chan = 0;
  int unsigned cnt = 0;

  task automatic chk(int act, int exp, string req, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(out_valid, e_valid, vtag, "out_valid");
    if (e_valid && out_valid) begin
      chk(out_sample, e_sample, "R2", "sample");
      chk(out_chan, e_chan, e_lfp ? "R5" : "R4", "chan");
      chk(out_is_lfp, e_lfp, e_lfp ? "R5" : "R4", "is_lfp");
    end
    chk(out_sosf, e_sosf, "R6", "sosf");
    chk(out_souf, e_souf, "R6", "souf");
    chk(sync_err, e_serr, etag, "sync_err");
    chk(drop, e_drop, "R7", "drop");
    chk(seq_err, e_seq, "R8", "seq_err");
    chk(drop_count, m_drops, "R7", "drop_count");
  endtask

  task automatic model(bit en, bit v, bit sob, logic [23:0] d);
    int code;
    bit err;
    e_valid = 0; e_sosf = 0; e_souf = 0; e_serr = 0; e_drop = 0; e_seq = 0;
    if (!rst_n) return;
    if (!en) begin
      m_inblk = 0; m_w = 0; m_lock = 0; m_ap = 0; m_sf = 0; m_kind = 0; m_first = 1;
      return;
    end
    if (!v) return;
    if (sob) begin
      code = int'(d[15:0]);
      err = m_inblk != 0;
      if (m_lock == 0 || err) begin
        m_lock = (code == 816); m_ap = 0; m_sf = 0; m_pos = 0; m_kind = m_lock ? 2 : 0;
      end else if (code == 816) begin
        if (m_ap == 12) m_sf = (m_sf + 1) % 12;
        else begin err = 1; m_sf = 0; end
        m_ap = 0; m_kind = 2; m_pos = m_sf;
      end else if (code == 207 && m_ap < 12) begin
        m_kind = 1; m_pos = m_ap; m_ap++;
      end else begin
        err = 1; m_lock = 0; m_kind = 0;
      end
      e_serr = err; m_inblk = 1; m_w = 1;
    end else if (m_inblk != 0) begin
      if (m_w == 1) begin
        if (m_first != 0) begin
          e_seq = (d != 0); m_first = 0;
        end else if (32'(d) != m_exp) begin
          e_drop = 1;
          if (m_drops < DMAX) m_drops++;
        end
        m_exp = (32'(d) + 1) & 32'hFFFFFF;
      end else if (m_kind != 0) begin
        e_valid = 1;
        e_sample = int'(d[9:0]);
        e_lfp = (m_kind == 2);
        e_chan = m_pos * 32 + (m_w - 2);
        e_sosf = e_lfp && (m_w == 2);
        e_souf = e_sosf && (m_pos == 0);
      end
      m_w++;
      if (m_w == 34) begin m_inblk = 0; m_w = 0; end
    end
  endtask

  task automatic step(bit en, bit v, bit sob, logic [23:0] d);
    @(posedge clk); #2;
    compare();
    enable = en; in_valid = v; in_sob = sob; in_data = d;
    model(en, v, sob, d);
  endtask

  task automatic send_block(int code, int unsigned c, bit gaps, int nsmp = 32);
    step(1, 1, 1, {8'($urandom), 16'(code)});
    step(1, 1, 0, 24'(c));
    for (int s = 0; s < nsmp; s++) begin
      if (gaps && (s % 7 == 3)) step(1, 0, 0, 24'($urandom));
      step(1, 1, 0, 24'($urandom));
    end
  endtask

  task automatic next_block(int code, bit gaps);
    send_block(code, cnt, gaps);
    cnt = (cnt + 1) & 32'hFFFFFF;
  endtask

  task automatic super_frame(int n_ap, bit gaps);
    next_block(816, gaps);
    for (int j = 0; j < n_ap; j++) next_block(207, gaps);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R10: outputs held at zero in reset
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    vtag = "R2"; etag = "R3";
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0);
    step(1, 1, 0, 24'h000330);          // R1: stray word, no block open
    // R4 R5 R6: two ultra frames with gaps and stray words
    for (int k = 0; k < 24; k++) begin
      super_frame(12, (k % 5) == 2);
      if (k % 9 == 4) step(1, 1, 0, 24'hFFFFFF);
    end
    // R7: jump near top, then wrap through zero
    send_block(816, 24'hFFFFFE, 0); cnt = 24'hFFFFFF;
    next_block(207, 0); next_block(207, 0);
    for (int j = 0; j < 10; j++) next_block(207, 0);
    // R3: thirteenth AP block, then a dropped one, then relock
    next_block(207, 0); next_block(207, 0);
    super_frame(5, 0);
    super_frame(12, 0);                 // early 816 resyncs
    next_block(16'h0123, 0);            // unknown code
    super_frame(3, 0);
    // R1: truncated AP block abandoned by a new start
    etag = "R1";
    send_block(207, cnt, 0, 10); cnt++;
    super_frame(12, 0);
    etag = "R3";
    super_frame(2, 0);
    // R9: disabled, input ignored
    vtag = "R9";
    for (int i = 0; i < 40; i++) step(0, 1, (i % 34) == 0, (i % 34) == 0 ? 24'd816 : 24'(i));
    vtag = "R2";
    // R8: nonzero restart count
    cnt = 5;
    super_frame(12, 0);
    next_block(816, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0);
    cnt = 0;                            // R8: zero restart count is clean
    super_frame(4, 0);
    // R7: saturation with truncated blocks
    etag = "R1";
    for (int i = 0; i < 70; i++) begin
      step(1, 1, 1, 24'd816);
      cnt = cnt + 3;
      step(1, 1, 0, 24'(cnt));
    end
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule